// File: doc/BRIEF.md
# Key-Unlocked Configuration Register Image

This block is a word-addressed bank of shadow registers holding a copy of a PCI configuration header. It sits on a plain 32-bit register bus. Every write stores a full word. A read returns its data on a registered output one cycle after the read strobe. Software uses it to see and adjust the identity and base-address words that the bus front end presents. The block also drives the decoded DRAM and MMIO base addresses to the routing logic.

Two groups of registers are guarded by a one-byte key. Writing the key to a group's field in the unlock word opens that group. For the subsystem group and the setup group, a write to the group's relocking register closes it again. A management-enable bit in the setup word gates writes to the command word, the latency timer, the cache line size and both base-address registers. The class code can be written once only. After an accepted base-address write, a settling flag stays high for a fixed number of cycles, because the decoded bases must not be relied on during that time.

Each key group is a small two-state machine with the states LOCKED and OPEN:
- LOCKED to OPEN: the unlock word is written with the key in the group's field.
- OPEN to LOCKED: the group's field is written with any other value, or the group's relocking register is written.

The settling tracker has the states IDLE and SETTLE:
- IDLE to SETTLE: a base-address write is accepted.
- SETTLE to SETTLE: the count is reloaded when another accepted base-address write arrives.
- SETTLE to IDLE: the count runs out.

Top module: `cfgimg_top`

Address map (byte offsets):

| Offset | Contents |
|---|---|
| 0x00 | identity word |
| 0x04 | status[31:16], command[15:0] |
| 0x08 | class code[31:8], revision[7:0] |
| 0x0C | BIST[31:24], header type[23:16], latency timer[15:8], cache line size[7:0] |
| 0x10 | BAR0 |
| 0x14 | BAR1 |
| 0x18 | subsystem word |
| 0x1C | max latency[15:8], min grant[7:0] |
| 0x20 | setup: bit 1 is management enable, bit 0 is the prefetchable source |
| 0x24 | unlock word |

## Requirements
- R1: After reset, the block reads as follows: identity 0x54051131, command/status word 0x02900000, class/revision word 0x04800001, BAR1 0x1BE00000. BAR0, the subsystem word, the latency/grant word, the setup word and the word at 0x0C all read 0.
- R2: The identity word at 0x00 and the status half [31:16] of the word at 0x04 cannot be written. They always read 0x54051131 and 0x0290.
- R3: Writing 0xCA to bits [15:8] of the unlock word (0x24) opens the subsystem group (0x18). Writing any other value to that field leaves the group locked.
- R4: Writing 0xCA to bits [7:0] of the unlock word opens the setup group. The group covers the class code (0x08), the latency/grant word (0x1C) and the setup word (0x20). Writing any other value to that field locks the group. Writes to the class code or the latency/grant word do not close the group.
- R5: A write to a locked group's register is ignored. Any write to 0x18 relocks the subsystem group, and any write to 0x20 relocks the setup group.
- R6: The following accept writes only while setup bit 1 is 1: the command half of 0x04, the latency timer and cache line size at 0x0C, and the writable bits of both BARs. When the bit is 0, they keep their value.
- R7: The 24-bit class code takes only its first accepted write. Later writes are ignored, and the revision byte always reads 1.
- R8: In BAR0 only bits [31:21] are writable. Bits [20:4] and [2:0] read 0, and bit 3 reads setup bit 0.
- R9: In BAR1 bits [31:4] are writable and bits [3:0] read 0.
- R10: An accepted BAR write raises base_settling for exactly 10 cycles, starting the cycle after the write. A further accepted BAR write restarts the count. An ignored BAR write does not raise the flag.
- R11: The unlock word, the BIST and header type bytes, and every unmapped offset read 0.
- R12: rd_data updates one cycle after rd_en and holds its value while rd_en is low.
- R13: dram_base equals BAR0 bits [31:21] with the low bits zero. mmio_base equals BAR1 bits [31:4] with the low bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register |
| wr_en | input | 1 | Write strobe, full-word write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| dram_base | output | 32 | Decoded DRAM base from BAR0 |
| mmio_base | output | 32 | Decoded MMIO base from BAR1 |
| base_settling | output | 1 | High while the decoded bases settle |

## Verification
On every cycle, the assertions check the following:
- The identity and status reads are constant.
- The key field reads 0.
- The subsystem group closes after a write to it.
- The decoded bases do not move while management is disabled.
- The class code is frozen once it has been written.
- The settling flag follows an accepted BAR write, never runs longer than its window, and falls only after exactly that window.

Only the bench scenarios can show the rest:
- A wrong key byte leaves a group shut.
- The setup group stays open across class and latency/grant writes.
- A second class write is dropped.
- A restart of the settling window extends the flag.
- The prefetchable bit of BAR0 follows the setup word.

// File: rtl/cfgimg_pkg.sv
package cfgimg_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_ID      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CMDSTAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CLASS   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MISC    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_BAR0    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_BAR1    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SUBSYS  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LATGNT  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SETUP   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_UNLOCK  = 8'h24;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hCA;

    localparam int NUM_GRP    = 2;
    localparam int GRP_SETUP  = 0;
    localparam int GRP_SUBSYS = 1;

    typedef enum logic {KL_LOCKED, KL_OPEN} kl_state_e;
    typedef enum logic {ST_IDLE, ST_SETTLE} st_state_e;
endpackage

// File: rtl/cfgimg_keylock.sv
module cfgimg_keylock
    import cfgimg_pkg::*;
#(
    parameter int               KW  = KEY_W,
    parameter logic [KW-1:0]    KEY = UNLOCK_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [KW-1:0] key_val,
    input  logic          relock,
    output logic          is_open
);
    kl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KL_LOCKED: if (key_wr && key_val == KEY) state_d = KL_OPEN;
            KL_OPEN: begin
                if (key_wr && key_val != KEY) state_d = KL_LOCKED;
                else if (relock)              state_d = KL_LOCKED;
            end
            default: state_d = KL_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        is_open = (state_q == KL_OPEN);
    end
endmodule

// File: rtl/cfgimg_settle.sv
module cfgimg_settle
    import cfgimg_pkg::*;
#(
    parameter int CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYC - 1);

    st_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_SETTLE: begin
                if (start) begin
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy = (state_q == ST_SETTLE);
    end
endmodule

// File: rtl/cfgimg_top.sv
module cfgimg_top
    import cfgimg_pkg::*;
#(
    parameter logic [31:0] DEVICE_VENDOR = 32'h5405_1131,
    parameter logic [15:0] STATUS_VAL    = 16'h0290,
    parameter logic [23:0] CLASS_RST     = 24'h04_8000,
    parameter logic [7:0]  REV_ID        = 8'h01,
    parameter logic [31:0] BAR1_RST      = 32'h1BE0_0000,
    parameter int          BAR0_LSB      = 21,
    parameter int          BAR1_LSB      = 4,
    parameter int          SETTLE_CYC    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dram_base,
    output logic [DATA_W-1:0] mmio_base,
    output logic              base_settling
);
    localparam int BAR0_W = DATA_W - BAR0_LSB;
    localparam int BAR1_W = DATA_W - BAR1_LSB;
    localparam int RSV0_W = BAR0_LSB - 4;

    logic wr_cmd, wr_class, wr_misc, wr_bar0, wr_bar1;
    logic wr_subsys, wr_latgnt, wr_setup, wr_unlock;

    always_comb begin
        wr_cmd    = wr_en && (addr == OFS_CMDSTAT);
        wr_class  = wr_en && (addr == OFS_CLASS);
        wr_misc   = wr_en && (addr == OFS_MISC);
        wr_bar0   = wr_en && (addr == OFS_BAR0);
        wr_bar1   = wr_en && (addr == OFS_BAR1);
        wr_subsys = wr_en && (addr == OFS_SUBSYS);
        wr_latgnt = wr_en && (addr == OFS_LATGNT);
        wr_setup  = wr_en && (addr == OFS_SETUP);
        wr_unlock = wr_en && (addr == OFS_UNLOCK);
    end

    logic [NUM_GRP-1:0] grp_open;
    logic [NUM_GRP-1:0] grp_relock;

    always_comb begin
        grp_relock             = '0;
        grp_relock[GRP_SETUP]  = wr_setup;
        grp_relock[GRP_SUBSYS] = wr_subsys;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cfgimg_keylock #(.KW(KEY_W), .KEY(UNLOCK_KEY)) u_keylock (
            .clk     (clk),
            .rst_n   (rst_n),
            .key_wr  (wr_unlock),
            .key_val (wr_data[g*KEY_W +: KEY_W]),
            .relock  (grp_relock[g]),
            .is_open (grp_open[g])
        );
    end

    logic [1:0]        setup_q;
    logic [15:0]       cmd_q;
    logic [7:0]        lat_q;
    logic [7:0]        cls_q;
    logic [BAR0_W-1:0] bar0_q;
    logic [BAR1_W-1:0] bar1_q;
    logic [23:0]       class_q;
    logic              class_done;
    logic [31:0]       subsys_q;
    logic [15:0]       latgnt_q;
    logic              mgmt_en;
    logic              prefetch;
    logic              bar_wr_ok;

    always_comb begin
        mgmt_en   = setup_q[1];
        prefetch  = setup_q[0];
        bar_wr_ok = mgmt_en && (wr_bar0 || wr_bar1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q    <= '0;
            cmd_q      <= '0;
            lat_q      <= '0;
            cls_q      <= '0;
            bar0_q     <= '0;
            bar1_q     <= BAR1_RST[DATA_W-1:BAR1_LSB];
            class_q    <= CLASS_RST;
            class_done <= 1'b0;
            subsys_q   <= '0;
            latgnt_q   <= '0;
        end else begin
            if (wr_setup && grp_open[GRP_SETUP]) setup_q <= wr_data[1:0];
            if (wr_latgnt && grp_open[GRP_SETUP]) latgnt_q <= wr_data[15:0];
            if (wr_class && grp_open[GRP_SETUP] && !class_done) begin
                class_q    <= wr_data[31:8];
                class_done <= 1'b1;
            end
            if (wr_subsys && grp_open[GRP_SUBSYS]) subsys_q <= wr_data;
            if (mgmt_en) begin
                if (wr_cmd) cmd_q <= wr_data[15:0];
                if (wr_misc) begin
                    lat_q <= wr_data[15:8];
                    cls_q <= wr_data[7:0];
                end
                if (wr_bar0) bar0_q <= wr_data[DATA_W-1:BAR0_LSB];
                if (wr_bar1) bar1_q <= wr_data[DATA_W-1:BAR1_LSB];
            end
        end
    end

    cfgimg_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bar_wr_ok),
        .busy  (base_settling)
    );

    always_comb begin
        dram_base = {bar0_q, {BAR0_LSB{1'b0}}};
        mmio_base = {bar1_q, {BAR1_LSB{1'b0}}};
    end

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (addr)
            OFS_ID:      rd_mux = DEVICE_VENDOR;
            OFS_CMDSTAT: rd_mux = {STATUS_VAL, cmd_q};
            OFS_CLASS:   rd_mux = {class_q, REV_ID};
            OFS_MISC:    rd_mux = {16'h0000, lat_q, cls_q};
            OFS_BAR0:    rd_mux = {bar0_q, {RSV0_W{1'b0}}, prefetch, 3'b000};
            OFS_BAR1:    rd_mux = {bar1_q, {BAR1_LSB{1'b0}}};
            OFS_SUBSYS:  rd_mux = subsys_q;
            OFS_LATGNT:  rd_mux = {16'h0000, latgnt_q};
            OFS_SETUP:   rd_mux = {30'd0, setup_q};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/cfgimg_chk.sv
module cfgimg_chk
    import cfgimg_pkg::*;
#(
    parameter logic [31:0] ID_VAL     = 32'h5405_1131,
    parameter logic [15:0] STAT_VAL   = 16'h0290,
    parameter int          SETTLE_CYC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] dram_base,
    input logic [DATA_W-1:0] mmio_base,
    input logic              base_settling,
    input logic              mgmt_en,
    input logic              bar_wr_ok,
    input logic              sub_open,
    input logic              class_done,
    input logic [23:0]       class_val
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hi_cnt <= '0;
        else if (bar_wr_ok)     hi_cnt <= '0;
        else if (base_settling) hi_cnt <= hi_cnt + 1'b1;
        else                    hi_cnt <= '0;
    end

    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_ID) |=> rd_data == ID_VAL); // R2
    AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CMDSTAT) |=> rd_data[31:16] == STAT_VAL); // R2
    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_UNLOCK) |=> rd_data == '0); // R11
    AST_SUBSYS_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SUBSYS) |=> !sub_open); // R5
    AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> ($stable(dram_base) && $stable(mmio_base))); // R6
    AST_CLASS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        class_done |=> $stable(class_val)); // R7
    AST_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        bar_wr_ok |=> base_settling); // R10
    AST_SETTLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        base_settling |-> hi_cnt < 8'(SETTLE_CYC)); // R10
    AST_SETTLE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(base_settling) |-> hi_cnt == 8'(SETTLE_CYC)); // R10
endmodule

bind cfgimg_top cfgimg_chk u_cfgimg_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .dram_base     (dram_base),
    .mmio_base     (mmio_base),
    .base_settling (base_settling),
    .mgmt_en       (mgmt_en),
    .bar_wr_ok     (bar_wr_ok),
    .sub_open      (grp_open[1]),
    .class_done    (class_done),
    .class_val     (class_q)
);

// File: tb/test_cfgimg_top.sv
module test_cfgimg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] dram_base;
    logic [31:0] mmio_base;
    logic        base_settling;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    logic [7:0]  adr_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;

    always #10 clk = ~clk;

    cfgimg_top i_cfgimg_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .dram_base     (dram_base),
        .mmio_base     (mmio_base),
        .base_settling (base_settling)
    );

    always @(posedge clk) rd_q <= rd_en;

    // monitor: pops the expected item once the registered read data appears
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [31:0] e;
            logic [7:0]  a;
            string       t;
            e = exp_q.pop_front();
            a = adr_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (rd_data !== e) begin
                n_bad++;
                $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", t, a, rd_data, e);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); adr_q.push_back(a); tag_q.push_back(tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // called at the negedge just after the write task returns
    task automatic settle_window(input string tag);
        for (int i = 0; i < 10; i++) begin
            chk({31'd0, base_settling}, 32'd1, tag);
            @(negedge clk);
        end
        chk({31'd0, base_settling}, 32'd0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data, 32'h0, "R12 reset rd_data");
        chk({31'd0, base_settling}, 32'd0, "R10 reset flag");
        chk(dram_base, 32'h0, "R13 reset dram_base");
        chk(mmio_base, 32'h1BE0_0000, "R13 reset mmio_base");
        rd(8'h00, 32'h5405_1131, "R1 id");
        rd(8'h04, 32'h0290_0000, "R1 cmdstat");
        rd(8'h08, 32'h0480_0001, "R1 class");
        rd(8'h0C, 32'h0, "R1 misc");
        rd(8'h10, 32'h0, "R1 bar0");
        rd(8'h14, 32'h1BE0_0000, "R1 bar1");
        rd(8'h18, 32'h0, "R1 subsys");
        rd(8'h1C, 32'h0, "R1 latgnt");
        rd(8'h20, 32'h0, "R1 setup");
        rd(8'h24, 32'h0, "R11 unlock reads 0");
        rd(8'h3C, 32'h0, "R11 unmapped");

        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h5405_1131, "R2 id write ignored");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0290_0000, "R6 cmd without mgmt");
        wr(8'h10, 32'hFFFF_FFFF);
        chk({31'd0, base_settling}, 32'd0, "R10 ignored bar write no flag");
        rd(8'h10, 32'h0, "R6 bar0 without mgmt");

        wr(8'h20, 32'h3);
        rd(8'h20, 32'h0, "R5 setup write while locked");
        wr(8'h24, 32'h0000_00CA);
        wr(8'h20, 32'h3);
        rd(8'h20, 32'h3, "R4 setup write when open");
        wr(8'h20, 32'h0);
        rd(8'h20, 32'h3, "R5 setup relocked");

        wr(8'h10, 32'hFFFF_FFFF);
        settle_window("R10 bar0 settle");
        rd(8'h10, 32'hFFE0_0008, "R8 bar0 layout");
        chk(dram_base, 32'hFFE0_0000, "R13 dram_base");

        wr(8'h14, 32'h1234_567F);
        repeat (4) @(negedge clk);
        chk({31'd0, base_settling}, 32'd1, "R10 mid window");
        wr(8'h14, 32'h1234_567F);
        settle_window("R10 restart");
        rd(8'h14, 32'h1234_5670, "R9 bar1 layout");
        chk(mmio_base, 32'h1234_5670, "R13 mmio_base");

        wr(8'h04, 32'h1234_ABCD);
        rd(8'h04, 32'h0290_ABCD, "R6 cmd with mgmt, R2 status");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0000_FFFF, "R6 lat/cls, R11 bist/hdr");

        wr(8'h08, 32'h1122_3344);
        rd(8'h08, 32'h0480_0001, "R5 class while locked");
        wr(8'h24, 32'h0000_00CA);
        wr(8'h08, 32'h1122_3344);
        rd(8'h08, 32'h1122_3301, "R7 first class write");
        wr(8'h08, 32'h5566_7788);
        rd(8'h08, 32'h1122_3301, "R7 second class write");
        wr(8'h1C, 32'h0000_ABCD);
        rd(8'h1C, 32'h0000_ABCD, "R4 group open after class");
        wr(8'h24, 32'h0000_0055);
        wr(8'h1C, 32'h0000_1111);
        rd(8'h1C, 32'h0000_ABCD, "R4 wrong key locks");

        wr(8'h18, 32'hDEAD_BEEF);
        rd(8'h18, 32'h0, "R5 subsys locked");
        wr(8'h24, 32'h0000_CB00);
        wr(8'h18, 32'hDEAD_BEEF);
        rd(8'h18, 32'h0, "R3 wrong key");
        wr(8'h24, 32'h0000_CA00);
        wr(8'h18, 32'hDEAD_BEEF);
        rd(8'h18, 32'hDEAD_BEEF, "R3 subsys open");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'hDEAD_BEEF, "R5 subsys relocked");
        repeat (3) @(negedge clk);
        chk(rd_data, 32'hDEAD_BEEF, "R12 rd_data held");

        wr(8'h24, 32'h0000_00CA);
        wr(8'h20, 32'h1);
        rd(8'h20, 32'h1, "R4 setup mgmt off");
        wr(8'h10, 32'h0);
        chk({31'd0, base_settling}, 32'd0, "R10 no flag mgmt off");
        rd(8'h10, 32'hFFE0_0008, "R6 bar0 frozen");
        wr(8'h24, 32'h0000_00CA);
        wr(8'h20, 32'h0);
        rd(8'h10, 32'hFFE0_0000, "R8 prefetch bit follows setup");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule